// File: doc/BRIEF.md
# Seeded Multi-Register Keystream Cipher

This block encrypts a serial message one bit per clock. Four 8-bit shift registers step in parallel. Each one has its own configuration register, and that register sets which of its bits feed back. The configuration registers are not wired to fixed values. They are filled from a small constant polynomial table whenever a seed is loaded. The low bits of the seed pick the table entry, and the rest of the seed gives the starting contents of the shift registers.

The bit leaving each shift register goes into a combinational combining function. That function gives one keystream bit per clock, and the keystream bit is XORed with the incoming message bit to give the ciphertext bit. A load strobe takes the whole seed in a single cycle, and ciphertext is valid from the next cycle on. A later strobe reloads the block while it is running.

Top module: `mlfsr_top`

## Requirements
- R1: A synchronous active-high reset clears every shift register and every configuration register to zero. It also drives `ct_valid` low.
- R2: When `load` is high, the block captures the seed in that same cycle. Bits `seed[2:0]` are the table index. Shift register i takes `seed[3+8*i +: 8]`, where seed bit 3+8*i+j goes to register bit j. `ct_valid` is high from the next cycle on.
- R3: The polynomial table entry e(i) for index i is 0x80 + 0x01 + 2*((29*i + 3*i*i) mod 64). A load writes the selected entry into all four configuration registers. An all-zero seed therefore writes entry 0 (0x81) everywhere, and every entry has bit 0 set.
- R4: On each clock where `ct_valid` is high and `load` is low, every shift register sr becomes {parity(cr & sr), sr[7:1]}. The output bit of that register is sr[0].
- R5: A configuration register changes only on reset or on a load.
- R6: With c the number of register output bits equal to 1, the keystream bit is (c >= 3) XOR (c odd). While `ct_valid` is high, `ct` = `msg` XOR keystream, combinationally in the same cycle.
- R7: Take configuration 0x81 and a shift register holding 0x01. After 8 steps that register is all ones.
- R8: A load while running takes priority over stepping. The freshly loaded state is not stepped in its load cycle.
- R9: Reset takes priority over a load in the same cycle.
- R10: While `ct_valid` is low, `ct` is 0 whatever `msg` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Seed load strobe |
| seed | input | 35 | Table index (bits 2:0) and shift register start values |
| msg | input | 1 | Message bit |
| ct | output | 1 | Ciphertext bit |
| ct_valid | output | 1 | Ciphertext stream is running |

## Verification
A load strobe can arrive in a cycle where the shift registers would otherwise step. Reset can also arrive in the same cycle as a load. The bench raises `load` mid-stream at random, and it also asserts reset together with a load. After each such cycle it compares the ciphertext against a model in which the new seed takes effect unstepped and reset wins. A mistaken step or a surviving seed shows up as a wrong ciphertext bit or a wrong `ct_valid` in the following cycle.

// File: rtl/mlfsr_pkg.sv
package mlfsr_pkg;

    localparam int N_DEF  = 8;
    localparam int S_DEF  = 4;
    localparam int W1_DEF = 3;

    typedef enum logic [1:0] {
        MD_HOLD = 2'd0,
        MD_LOAD = 2'd1,
        MD_STEP = 2'd2
    } reg_mode_e;

    // Table entry: top and bottom taps always set, middle bits computed from the index.
    function automatic logic [31:0] poly_entry(input int idx, input int n);
        logic [31:0] mid;
        logic [31:0] e;
        mid = 32'((29 * idx + 3 * idx * idx) % (1 << (n - 2)));
        e   = (32'd1 << (n - 1)) | 32'd1 | (mid << 1);
        return e;
    endfunction

endpackage

// File: rtl/mlfsr_poly_rom.sv
module mlfsr_poly_rom
    import mlfsr_pkg::*;
#(
    parameter int N  = N_DEF,
    parameter int W1 = W1_DEF
) (
    input  logic [W1-1:0] addr,
    output logic [N-1:0]  entry
);
    localparam int DEPTH = 1 << W1;

    logic [N-1:0] table_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        logic [31:0] full;
        assign full       = poly_entry(i, N);
        assign table_q[i] = full[N-1:0];
    end

    assign entry = table_q[addr];
endmodule

// File: rtl/mlfsr_cell.sv
module mlfsr_cell
    import mlfsr_pkg::*;
#(
    parameter int N = N_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  reg_mode_e mode,
    input  logic [N-1:0] sr_init,
    input  logic [N-1:0] cr_init,
    output logic [N-1:0] sr,
    output logic [N-1:0] cr,
    output logic         out_bit
);
    logic fb;

    assign fb      = ^(cr & sr);
    assign out_bit = sr[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
            cr <= '0;
        end else begin
            case (mode)
                MD_LOAD: begin
                    sr <= sr_init;
                    cr <= cr_init;
                end
                MD_STEP: sr <= {fb, sr[N-1:1]};
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mlfsr_combine.sv
module mlfsr_combine
    import mlfsr_pkg::*;
#(
    parameter int S = S_DEF
) (
    input  logic [S-1:0] bits,
    output logic         ks
);
    localparam int CW = $clog2(S + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        cnt = '0;
        for (int i = 0; i < S; i++) cnt = cnt + CW'(bits[i]);
    end

    assign ks = (32'(cnt) > (S / 2)) ^ (^bits);
endmodule

// File: rtl/mlfsr_top.sv
module mlfsr_top
    import mlfsr_pkg::*;
#(
    parameter int N  = N_DEF,
    parameter int S  = S_DEF,
    parameter int W1 = W1_DEF,
    localparam int SW = W1 + S * N
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [SW-1:0] seed,
    input  logic          msg,
    output logic          ct,
    output logic          ct_valid
);
    logic                   running;
    reg_mode_e              mode;
    logic [N-1:0]           poly;
    logic [S-1:0]           outs;
    logic [S-1:0][N-1:0]    sr_bus;
    logic [S-1:0][N-1:0]    cr_bus;
    logic                   ks;

    always_ff @(posedge clk) begin
        if (rst)       running <= 1'b0;
        else if (load) running <= 1'b1;
    end

    always_comb begin
        if (load)         mode = MD_LOAD;
        else if (running) mode = MD_STEP;
        else              mode = MD_HOLD;
    end

    mlfsr_poly_rom #(.N(N), .W1(W1)) u_rom (
        .addr  (seed[W1-1:0]),
        .entry (poly)
    );

    for (genvar i = 0; i < S; i++) begin : g_cell
        mlfsr_cell #(.N(N)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .mode    (mode),
            .sr_init (seed[W1 + i*N +: N]),
            .cr_init (poly),
            .sr      (sr_bus[i]),
            .cr      (cr_bus[i]),
            .out_bit (outs[i])
        );
    end

    mlfsr_combine #(.S(S)) u_comb (
        .bits (outs),
        .ks   (ks)
    );

    assign ct       = running & (msg ^ ks);
    assign ct_valid = running;
endmodule

// File: rtl/mlfsr_chk.sv
module mlfsr_chk
    import mlfsr_pkg::*;
#(
    parameter int N  = N_DEF,
    parameter int S  = S_DEF,
    parameter int W1 = W1_DEF,
    localparam int SW = W1 + S * N
) (
    input logic                clk,
    input logic                rst,
    input logic                load,
    input logic [SW-1:0]       seed,
    input logic                msg,
    input logic                ct,
    input logic                ct_valid,
    input logic [S-1:0][N-1:0] sr_bus,
    input logic [S-1:0][N-1:0] cr_bus
);
    logic [31:0] e0;
    assign e0 = poly_entry(0, N);

    // R1, R9: reset clears state and wins over load
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!ct_valid && sr_bus == '0 && cr_bus == '0));

    // R2: a load makes the stream valid next cycle
    p_load_valid_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> ct_valid);

    // R3: zero seed selects entry 0 for all registers
    p_zero_seed_r3: assert property (@(posedge clk) disable iff (rst)
        (load && seed == '0) |=> (cr_bus == {S{e0[N-1:0]}}));

    // R5: configuration stable without load
    p_cr_stable_r5: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(cr_bus));

    // R10: idle output is zero
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !ct_valid |-> !ct);

    for (genvar i = 0; i < S; i++) begin : g_a
        // R3: every running configuration keeps its bottom tap
        p_tap_low_r3: assert property (@(posedge clk) disable iff (rst)
            ct_valid |-> cr_bus[i][0]);
        // R4, R8: shift-right step only when running without load
        p_shift_r4: assert property (@(posedge clk) disable iff (rst)
            (ct_valid && !load) |=> (sr_bus[i][N-2:0] == $past(sr_bus[i][N-1:1])));
    end
endmodule

bind mlfsr_top mlfsr_chk #(.N(N), .S(S), .W1(W1)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .seed     (seed),
    .msg      (msg),
    .ct       (ct),
    .ct_valid (ct_valid),
    .sr_bus   (sr_bus),
    .cr_bus   (cr_bus)
);

// File: tb/mlfsr_top_tb.sv
`timescale 1ns/1ps
module mlfsr_top_tb;
    localparam int N  = 8;
    localparam int S  = 4;
    localparam int W1 = 3;
    localparam int SW = W1 + S * N;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          load = 1'b0;
    logic [SW-1:0] seed = '0;
    logic          msg = 1'b0;
    logic          ct;
    logic          ct_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [N-1:0] m_sr [S];
    logic [N-1:0] m_cr [S];
    logic         m_run;

    always #4 clk = ~clk;

    mlfsr_top u_dut (
        .clk(clk), .rst(rst), .load(load), .seed(seed),
        .msg(msg), .ct(ct), .ct_valid(ct_valid)
    );

    function automatic logic [N-1:0] rom_m(input int i);
        int mid;
        mid = (29 * i + 3 * i * i) % 64;
        return 8'(128 + 1 + 2 * mid);
    endfunction

    function automatic logic ks_m();
        int c;
        c = 0;
        for (int i = 0; i < S; i++) c += int'(m_sr[i][0]);
        return logic'((c >= 3) ^ (c % 2 == 1));
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (rst) begin
            m_run = 0;
            for (int i = 0; i < S; i++) begin m_sr[i] = '0; m_cr[i] = '0; end
        end else if (load) begin
            m_run = 1;
            for (int i = 0; i < S; i++) begin
                m_cr[i] = rom_m(int'(seed[W1-1:0]));
                m_sr[i] = seed[W1 + i*N +: N];
            end
        end else if (m_run) begin
            for (int i = 0; i < S; i++)
                m_sr[i] = {^(m_cr[i] & m_sr[i]), m_sr[i][N-1:1]};
        end
    endtask

    // one cycle: drive at negedge, compare outputs, advance model for the coming edge
    task automatic cyc(input logic r, input logic ld, input logic [SW-1:0] sd,
                       input logic m, input string req);
        @(negedge clk);
        rst = r; load = ld; seed = sd; msg = m;
        #1;
        chk({req, " valid"}, ct_valid, m_run);
        chk({req, " ct"}, ct, m_run ? (m ^ ks_m()) : 1'b0);
        model_edge();
    endtask

    initial begin
        logic [SW-1:0] s7;
        void'($urandom(32'd1234));
        m_run = 0;
        for (int i = 0; i < S; i++) begin m_sr[i] = '0; m_cr[i] = '0; end
        cyc(1, 0, '0, 0, "R1");
        cyc(1, 0, '0, 1, "R1");
        // R10: idle, message toggles ignored
        for (int k = 0; k < 4; k++) cyc(0, 0, '0, logic'(k), "R10");
        // R3: all-zero seed, keystream zero
        cyc(0, 1, '0, 1, "R3");
        for (int k = 0; k < 6; k++) cyc(0, 0, '0, logic'(k & 1), "R3");
        // R7: register 0 holds 0x01, entry 0 taps
        s7 = '0; s7[W1] = 1'b1;
        cyc(0, 1, s7, 0, "R7");
        for (int k = 0; k < 8; k++) cyc(0, 0, '0, 0, "R7");
        @(negedge clk); #1;
        chk("R7 all ones", ct, 1'b1);
        // R9: reset with load
        cyc(1, 1, {$urandom, $urandom}, 1, "R9");
        cyc(0, 0, '0, 1, "R9");
        // R2 R4 R5 R6 R8: random stream with random reloads
        for (int k = 0; k < 4000; k++) begin
            logic [SW-1:0] sd;
            sd = SW'({$urandom, $urandom});
            cyc(($urandom % 400) == 0, ($urandom % 25) == 0 || k == 0, sd,
                logic'($urandom & 1), "R6");
        end
        // R8: back-to-back loads
        for (int k = 0; k < 6; k++) cyc(0, 1, SW'({$urandom, $urandom}), logic'(k & 1), "R8");
        for (int k = 0; k < 10; k++) cyc(0, 0, '0, 1, "R4");
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule